// File: doc/BRIEF.md
# Time-of-Day Alarm and Periodic Interrupt Controller

This block sits beside a real-time-clock timekeeping core. It watches the running second, minute, hour and weekday that the core presents, and raises interrupts from them. The block holds up to two alarms. Each alarm has a minute value, an hour value and a seven-bit weekday mask. When the time reaches second 00 of a matching minute, the alarm sets a sticky flag. The shared active-low alarm pin is pulled low while any alarm has both its flag and its enable set.

A second interrupt pin carries a periodic source. Its rate comes from a three-bit field. Three event rates give a latched, pulse-like flag. One mode drives the pin as a 1 Hz square wave that is low during the first half of every second. The registers are reached through a simple synchronous write port and a combinational read port, both owned by the host bus bridge. The time counters themselves live outside the block.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, both interrupt pins are high and every register at addresses 8 to 15 reads 0x00.
- R2: Address 8 holds alarm 0 minute, 9 its hour and 10 its weekday mask; addresses 11, 12 and 13 hold the same three for alarm 1. Minute and hour read back as written. A mask reads back with bit 7 as 0. Control 1 (address 14) keeps only bits 7, 6 and 2:0 and reads 0 in bits 5:3. A write is visible on the next clock.
- R3: An alarm matches on a clock where `tick_sec` is 1, the current second is 00, the minute equals the alarm minute in bits 6:0, the hour equals the alarm hour in bits 5:0 (so the 12/24-hour encodings compare as stored), and the weekday value 0..6 selects a set mask bit. Weekday 7 never matches. A match sets the alarm's flag on that clock edge. Alarm 0's flag is control 2 bit 1.
- R4: A flag is set by a match whatever the enable says. `irq_alarm_n` is low exactly while some alarm has both its flag and its enable (control 1 bit 7 for alarm 0) set.
- R5: A flag stays set until a control 2 write carries 0 in its bit. A write of 1 to a flag bit leaves it unchanged.
- R6: A control 1 write with an alarm's enable bit at 0 clears that alarm's flag, even if the flag is set in the same cycle.
- R7: Alarm 1 uses the registers at 11 to 13, the enable at control 1 bit 6 and the flag at control 2 bit 0. It drives the same `irq_alarm_n` pin.
- R8: With control 1 bits 2:0 = 4, `irq_per_n` equals `half_sec`, so it is low in the first half of each second. The periodic flag (control 2 bit 2) is set on every `tick_sec`.
- R9: With rate 1 the periodic flag is set on every tick. With rate 2 it is set on ticks at second 00. With rate 3 it is set on ticks at second 00 and minute 00. In rates 1 to 3, `irq_per_n` is low while the flag is set. Rates 0, 5, 6 and 7 set no flag and keep `irq_per_n` high. The flag clears like alarm flags, through a 0 in bit 2 of a control 2 write.
- R10: When a match and a control 2 write clearing the same flag fall on one clock, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| tick_sec | input | 1 | One-clock pulse when the time advances to a new second |
| half_sec | input | 1 | High in the second half of each second |
| cur_sec | input | 7 | Current second, BCD |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD with 12/24-hour encoding |
| cur_wday | input | 3 | Current weekday 0..6 |
| irq_alarm_n | output | 1 | Active-low alarm interrupt |
| irq_per_n | output | 1 | Active-low periodic interrupt |

## Verification
Register writes and flag changes are each one clock deep. A write or a tick presented before a rising edge is visible at the read port after that edge. Both pins follow the registered flags and enables through logic only, and the 1 Hz level follows `half_sec` with no delay. The bench therefore changes inputs on falling edges and samples on the next falling edge, one full clock after the stimulus. It sweeps every weekday value against every single-bit mask, and every rate code against three time patterns. It reads the flags back through control 2 before each clearing write.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int DW        = 8;
  localparam int AW        = 4;
  localparam int MAX_ALARM = 2;
  localparam logic [AW-1:0] ADDR_ALM0  = 4'd8;
  localparam logic [AW-1:0] ADDR_CTRL1 = 4'd14;
  localparam logic [AW-1:0] ADDR_CTRL2 = 4'd15;
  localparam logic [2:0] RATE_SEC   = 3'd1;
  localparam logic [2:0] RATE_MIN   = 3'd2;
  localparam logic [2:0] RATE_HOUR  = 3'd3;
  localparam logic [2:0] RATE_LEVEL = 3'd4;

  // minute on 7 bits, hour on 6 bits, weekday selects a mask bit
  function automatic logic alarm_hit(input logic [6:0] sec, input logic [6:0] min,
                                     input logic [5:0] hour, input logic [2:0] wday,
                                     input logic [7:0] amin, input logic [7:0] ahour,
                                     input logic [6:0] amask);
    logic day_ok;
    day_ok = (wday < 3'd7) ? amask[wday] : 1'b0;
    return (sec == 7'h00) && (min == amin[6:0]) && (hour == ahour[5:0]) && day_ok;
  endfunction

  function automatic logic per_event(input logic [2:0] rate, input logic [6:0] sec,
                                     input logic [6:0] min);
    case (rate)
      RATE_SEC, RATE_LEVEL: return 1'b1;
      RATE_MIN:             return sec == 7'h00;
      RATE_HOUR:            return (sec == 7'h00) && (min == 7'h00);
      default:              return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_alarm_pkg::*;
#(
  parameter logic [AW-1:0] BASE = ADDR_ALM0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          tick,
  input  logic [6:0]    cur_sec,
  input  logic [6:0]    cur_min,
  input  logic [5:0]    cur_hour,
  input  logic [2:0]    cur_wday,
  input  logic          en_clr,
  input  logic          flag_clr,
  output logic          flag_q,
  output logic          hit,
  output logic [DW-1:0] amin_q,
  output logic [DW-1:0] ahour_q,
  output logic [6:0]    amask_q
);
  localparam logic [AW-1:0] A_MIN  = BASE;
  localparam logic [AW-1:0] A_HOUR = BASE + 4'd1;
  localparam logic [AW-1:0] A_MASK = BASE + 4'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amin_q  <= '0;
      ahour_q <= '0;
      amask_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_MIN)  amin_q  <= wr_data;
      if (wr_addr == A_HOUR) ahour_q <= wr_data;
      if (wr_addr == A_MASK) amask_q <= wr_data[6:0];
    end
  end

  assign hit = tick && alarm_hit(cur_sec, cur_min, cur_hour, cur_wday, amin_q, ahour_q, amask_q);

  // disable wins over a match; a match wins over a flag-clearing write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (en_clr)   flag_q <= 1'b0;
    else if (hit)      flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assert_hit_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !en_clr |=> flag_q);
  assert_disable_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr |=> !flag_q);
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !en_clr && !flag_clr |=> flag_q);
  assert_match_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit && flag_clr && !en_clr |=> flag_q);
endmodule

// File: rtl/rtc_periodic_gen.sv
module rtc_periodic_gen
  import rtc_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rate,
  input  logic       tick,
  input  logic       half_sec,
  input  logic [6:0] cur_sec,
  input  logic [6:0] cur_min,
  input  logic       flag_clr,
  output logic       flag_q,
  output logic       ev,
  output logic       irq_n
);
  assign ev = tick && per_event(rate, cur_sec, cur_min);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (ev)       flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  always_comb begin
    case (rate)
      RATE_LEVEL:                   irq_n = half_sec;
      RATE_SEC, RATE_MIN, RATE_HOUR: irq_n = !flag_q;
      default:                      irq_n = 1'b1;
    endcase
  end

  assert_level_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == RATE_LEVEL) && !half_sec |-> !irq_n);
  assert_event_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> flag_q);
  assert_idle_rate_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == 3'd0) |-> irq_n);
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int NUM_ALARMS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          tick_sec,
  input  logic          half_sec,
  input  logic [6:0]    cur_sec,
  input  logic [6:0]    cur_min,
  input  logic [5:0]    cur_hour,
  input  logic [2:0]    cur_wday,
  output logic          irq_alarm_n,
  output logic          irq_per_n
);
  localparam int STRIDE = 3;

  logic [MAX_ALARM-1:0] en_q, en_clr, flag_clr, flag, hit;
  logic [DW-1:0]        amin  [MAX_ALARM];
  logic [DW-1:0]        ahour [MAX_ALARM];
  logic [6:0]           amask [MAX_ALARM];
  logic [2:0]           rate_q;
  logic                 per_flag, per_ev;
  logic                 wr_c1, wr_c2;

  assign wr_c1 = wr_en && (wr_addr == ADDR_CTRL1);
  assign wr_c2 = wr_en && (wr_addr == ADDR_CTRL2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      rate_q <= '0;
    end else if (wr_c1) begin
      for (int i = 0; i < MAX_ALARM; i++) en_q[i] <= (i < NUM_ALARMS) && wr_data[7-i];
      rate_q <= wr_data[2:0];
    end
  end

  for (genvar g = 0; g < MAX_ALARM; g++) begin : g_alarm
    assign en_clr[g]   = wr_c1 && !wr_data[7-g];
    assign flag_clr[g] = wr_c2 && !wr_data[1-g];
    if (g < NUM_ALARMS) begin : g_on
      rtc_alarm_unit #(.BASE(ADDR_ALM0 + 4'(STRIDE * g))) u_alarm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tick(tick_sec), .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_wday(cur_wday), .en_clr(en_clr[g]), .flag_clr(flag_clr[g]),
        .flag_q(flag[g]), .hit(hit[g]), .amin_q(amin[g]), .ahour_q(ahour[g]),
        .amask_q(amask[g]));
    end else begin : g_off
      assign flag[g]  = 1'b0;
      assign hit[g]   = 1'b0;
      assign amin[g]  = '0;
      assign ahour[g] = '0;
      assign amask[g] = '0;
    end
  end

  rtc_periodic_gen u_per (
    .clk(clk), .rst_n(rst_n), .rate(rate_q), .tick(tick_sec), .half_sec(half_sec),
    .cur_sec(cur_sec), .cur_min(cur_min), .flag_clr(wr_c2 && !wr_data[2]),
    .flag_q(per_flag), .ev(per_ev), .irq_n(irq_per_n));

  assign irq_alarm_n = !(|(en_q & flag));

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < MAX_ALARM; i++) begin
      if (rd_addr == ADDR_ALM0 + 4'(STRIDE * i))     rd_data = amin[i];
      if (rd_addr == ADDR_ALM0 + 4'(STRIDE * i + 1)) rd_data = ahour[i];
      if (rd_addr == ADDR_ALM0 + 4'(STRIDE * i + 2)) rd_data = {1'b0, amask[i]};
    end
    if (rd_addr == ADDR_CTRL1) rd_data = {en_q[0], en_q[1], 3'b000, rate_q};
    if (rd_addr == ADDR_CTRL2) rd_data = {5'b00000, per_flag, flag[0], flag[1]};
  end

  assert_pin_quiet_when_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> irq_alarm_n);
  assert_pin_follows_enabled_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[0] && flag[0]) |-> !irq_alarm_n);
  assert_per_event_seen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    per_ev |=> per_flag);
endmodule

// File: tb/sim_rtc_alarm_irq.sv
`timescale 1ns/1ps
module sim_rtc_alarm_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       tick_sec = 1'b0;
  logic       half_sec = 1'b1;
  logic [6:0] cur_sec = '0;
  logic [6:0] cur_min = '0;
  logic [5:0] cur_hour = '0;
  logic [2:0] cur_wday = '0;
  logic       irq_alarm_n, irq_per_n;
  int         n_chk = 0;
  int         n_fail = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  rtc_alarm_irq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick_sec(tick_sec), .half_sec(half_sec),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_wday(cur_wday),
    .irq_alarm_n(irq_alarm_n), .irq_per_n(irq_per_n));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  // tick with optional same-cycle control 2 write
  task automatic tk(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                    input logic [2:0] w, input logic c2w, input logic [7:0] c2d);
    @(negedge clk);
    cur_sec = s; cur_min = m; cur_hour = h; cur_wday = w; tick_sec = 1'b1;
    wr_en = c2w; wr_addr = 4'd15; wr_data = c2d;
    @(negedge clk);
    tick_sec = 1'b0; wr_en = 1'b0;
  endtask

  function automatic logic per_exp(input int r, input logic [6:0] s, input logic [6:0] m);
    if (r == 1 || r == 4) return 1'b1;
    if (r == 2) return s == 7'h00;
    if (r == 3) return s == 7'h00 && m == 7'h00;
    return 1'b0;
  endfunction

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual expired expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq_alarm_n", {7'd0, irq_alarm_n}, 8'd1);
    chk("R1 irq_per_n", {7'd0, irq_per_n}, 8'd1);
    for (int a = 8; a < 16; a++) begin
      rd(4'(a), v); chk("R1 reg", v, 8'h00);
    end
    // R2 register write and read-back
    wr(4'd8, 8'h45);  rd(4'd8, v);  chk("R2 min0", v, 8'h45);
    wr(4'd9, 8'h23);  rd(4'd9, v);  chk("R2 hour0", v, 8'h23);
    wr(4'd10, 8'hFF); rd(4'd10, v); chk("R2 mask0", v, 8'h7F);
    wr(4'd11, 8'h05); rd(4'd11, v); chk("R2 min1", v, 8'h05);
    wr(4'd12, 8'h07); rd(4'd12, v); chk("R2 hour1", v, 8'h07);
    wr(4'd13, 8'h00); rd(4'd13, v); chk("R2 mask1", v, 8'h00);
    wr(4'd14, 8'hFF); rd(4'd14, v); chk("R2 ctrl1", v, 8'hC7);
    wr(4'd14, 8'h00);
    // R3 weekday sweep, enable off (R4 pin stays high)
    wr(4'd8, 8'h30); wr(4'd9, 8'h12);
    for (int k = 0; k < 7; k++) begin
      wr(4'd10, 8'(1 << k));
      for (int w = 0; w < 8; w++) begin
        tk(7'h00, 7'h30, 6'h12, 3'(w), 1'b0, 8'h00);
        rd(4'd15, v);
        chk("R3 wday sweep flag", v, (w == k) ? 8'h02 : 8'h00);
        chk("R4 pin idle while disabled", {7'd0, irq_alarm_n}, 8'd1);
        wr(4'd15, 8'h00);
      end
    end
    // R3 field comparisons
    wr(4'd10, 8'h7F);
    tk(7'h01, 7'h30, 6'h12, 3'd2, 1'b0, 8'h00); rd(4'd15, v); chk("R3 sec nonzero", v, 8'h00);
    tk(7'h00, 7'h31, 6'h12, 3'd2, 1'b0, 8'h00); rd(4'd15, v); chk("R3 min differs", v, 8'h00);
    tk(7'h00, 7'h30, 6'h32, 3'd2, 1'b0, 8'h00); rd(4'd15, v); chk("R3 pm bit differs", v, 8'h00);
    wr(4'd9, 8'h52); wr(4'd8, 8'hB0);
    tk(7'h00, 7'h30, 6'h12, 3'd2, 1'b0, 8'h00); rd(4'd15, v); chk("R3 high bits ignored", v, 8'h02);
    wr(4'd15, 8'h00); wr(4'd9, 8'h12); wr(4'd8, 8'h30);
    // R4 / R5 enabled alarm and sticky flag
    wr(4'd14, 8'h80);
    tk(7'h00, 7'h30, 6'h12, 3'd4, 1'b0, 8'h00);
    chk("R4 pin low on enabled match", {7'd0, irq_alarm_n}, 8'd0);
    wr(4'd15, 8'h07); rd(4'd15, v); chk("R5 write one keeps flag", v, 8'h02);
    tk(7'h00, 7'h10, 6'h12, 3'd4, 1'b0, 8'h00); rd(4'd15, v); chk("R5 sticky", v, 8'h02);
    chk("R5 pin held", {7'd0, irq_alarm_n}, 8'd0);
    wr(4'd15, 8'h00); rd(4'd15, v); chk("R5 write zero clears", v, 8'h00);
    chk("R5 pin released", {7'd0, irq_alarm_n}, 8'd1);
    // R6 disable clears; R4 flag with enable off then enabling
    tk(7'h00, 7'h30, 6'h12, 3'd0, 1'b0, 8'h00);
    wr(4'd14, 8'h00); rd(4'd15, v); chk("R6 disable clears flag", v, 8'h00);
    chk("R6 pin high", {7'd0, irq_alarm_n}, 8'd1);
    tk(7'h00, 7'h30, 6'h12, 3'd0, 1'b0, 8'h00);
    chk("R4 pin high with flag only", {7'd0, irq_alarm_n}, 8'd1);
    wr(4'd14, 8'h80);
    rd(4'd15, v); chk("R4 flag kept on enable", v, 8'h02);
    chk("R4 pin low after enable", {7'd0, irq_alarm_n}, 8'd0);
    wr(4'd14, 8'h00);
    // R7 second alarm
    wr(4'd13, 8'h7F); wr(4'd14, 8'h40);
    tk(7'h00, 7'h05, 6'h07, 3'd6, 1'b0, 8'h00); rd(4'd15, v); chk("R7 alarm1 flag", v, 8'h01);
    chk("R7 shared pin low", {7'd0, irq_alarm_n}, 8'd0);
    wr(4'd15, 8'h06); rd(4'd15, v); chk("R7 clear bit0", v, 8'h00);
    chk("R7 pin released", {7'd0, irq_alarm_n}, 8'd1);
    // R10 match and clearing write in one clock
    tk(7'h00, 7'h05, 6'h07, 3'd1, 1'b1, 8'h00); rd(4'd15, v); chk("R10 match wins", v, 8'h01);
    wr(4'd14, 8'h00); wr(4'd15, 8'h00);
    // R8 / R9 periodic sweep over every rate code
    for (int r = 0; r < 8; r++) begin
      wr(4'd14, 8'(r));
      for (int p = 0; p < 3; p++) begin
        logic [6:0] s, m;
        logic e;
        s = (p == 0) ? 7'h15 : 7'h00;
        m = (p == 2) ? 7'h00 : 7'h20;
        e = per_exp(r, s, m);
        half_sec = 1'b0;
        tk(s, m, 6'h01, 3'd3, 1'b0, 8'h00);
        rd(4'd15, v); chk("R9 periodic flag", v, {5'd0, e, 2'b00});
        if (r == 4) begin
          chk("R8 level low first half", {7'd0, irq_per_n}, 8'd0);
          half_sec = 1'b1; #1;
          chk("R8 level high second half", {7'd0, irq_per_n}, 8'd1);
        end else begin
          chk("R9 periodic pin", {7'd0, irq_per_n},
              {7'd0, !((r >= 1 && r <= 3) && e)});
        end
        wr(4'd15, 8'h00); rd(4'd15, v); chk("R9 periodic clear", v, 8'h00);
      end
    end
    half_sec = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule